// File: doc/BRIEF.md
# Replicated Register Bank With Steering

This block is a register target in which a single data address is backed by one copy of the same register per hardware unit. Units are arranged as groups, each holding several instances. A steering selector register holds a group number, an instance number and a broadcast flag. A data write with the flag set lands in every unit. With the flag clear, it lands only in the steered unit. A data read always returns the steered unit's copy, whatever the flag holds.

A per-unit enable mask, driven from outside, marks units that are fused off or powered down. A steered read of such a unit returns zero. A steered write to such a unit is dropped with no error, and a broadcast write skips it.

A hardware semaphore register lets several agents share the selector. Reading it returns 1 and takes the lock when the lock is free. Reading it returns 0 while the lock is already held. Writing 1 to it frees the lock.

Top module: `steer_reg_bank`

## Requirements
- R1: After reset, every copy holds 0, the semaphore is free and the selector reads back 0x00000001 (broadcast flag set, group 0, instance 0).
- R2: A data write (address 0) with the broadcast flag (selector bit 0) at 1 stores the value in every enabled copy in the same cycle.
- R3: A broadcast data write leaves every copy whose enable bit is 0 at its old value.
- R4: A data write with the broadcast flag at 0 changes only the copy with unit index group*4+instance; every other copy keeps its value.
- R5: A steered write to a unit whose enable bit is 0 changes no copy.
- R6: A data read returns the copy at unit index group*4+instance, with the same result whether the broadcast flag is 0 or 1.
- R7: A data read steered to a unit whose enable bit is 0 returns 0.
- R8: A read of the semaphore (address 2) returns 1 and takes the lock when the lock is free; while the lock is held, a read returns 0 and the lock stays held.
- R9: Writing a value with bit 0 set to the semaphore frees the lock; writing a value with bit 0 clear has no effect.
- R10: Every read gets its response one cycle later, with rsp_valid high for exactly that cycle; writes produce no response.
- R11: The selector (address 1) keeps the broadcast flag in bit 0, the group in bits 9:8 and the instance in bits 17:16; all other bits read back as 0, and address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | 0 data, 1 selector, 2 semaphore, 3 unused |
| req_wdata | input | 32 | Write data |
| unit_enable | input | 16 | Per-unit enable, bit index group*4+instance |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |

## Verification
The hardest condition to observe from the ports is a disabled copy that silently kept an old value through a broadcast or steered write, because a read of a disabled unit always returns zero. The bench therefore writes under a sparse enable mask, then raises every enable bit and reads each unit one by one. A dropped write then shows up as the earlier value, and a wrongly taken write shows up as the new one. Reads are repeated with the broadcast flag both set and clear, which shows that steering alone picks the copy.

// File: rtl/steer_pkg.sv
// Shared sizes and address codes for the replicated register bank.
// Assumes group and instance counts are powers of two and at most 256 each.
package steer_pkg;
    localparam int NUM_GROUPS = 4;
    localparam int NUM_INST   = 4;
    localparam int DATA_W     = 32;
    localparam int NUM_UNITS  = NUM_GROUPS * NUM_INST;
    localparam int GRP_W      = $clog2(NUM_GROUPS);
    localparam int INST_W     = $clog2(NUM_INST);
    localparam int UNIT_W     = $clog2(NUM_UNITS);
    localparam int GRP_LSB    = 8;
    localparam int INST_LSB   = 16;

    typedef enum logic [1:0] {
        ADDR_DATA = 2'd0,
        ADDR_SEL  = 2'd1,
        ADDR_SEM  = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/steer_selector.sv
// Steering selector: holds the broadcast flag, the group and the instance.
// Assumes the top hands in only the field slices of the write word.
module steer_selector
    import steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_mcast,
    input  logic [GRP_W-1:0]  wr_grp,
    input  logic [INST_W-1:0] wr_inst,
    output logic              mcast,
    output logic [GRP_W-1:0]  grp,
    output logic [INST_W-1:0] inst,
    output logic [DATA_W-1:0] sel_word
);
    // Load the three fields on a selector write; reset to broadcast at unit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcast <= 1'b1;
            grp   <= '0;
            inst  <= '0;
        end else if (wr_en) begin
            mcast <= wr_mcast;
            grp   <= wr_grp;
            inst  <= wr_inst;
        end
    end

    // Pack the fields at their bit positions; every other bit reads as zero.
    always_comb begin
        sel_word = '0;
        sel_word[0] = mcast;
        sel_word[GRP_LSB +: GRP_W]   = grp;
        sel_word[INST_LSB +: INST_W] = inst;
    end

    assert_sel_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sel_word));
endmodule

// File: rtl/steer_semaphore.sv
// Read-to-acquire lock: a read takes a free lock, a write of bit 0 frees it.
// Assumes read and write never arrive in the same cycle (one port).
module steer_semaphore (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic wr_bit,
    output logic grant,
    output logic held
);
    // A read of a free lock is granted.
    assign grant = rd_hit && !held;

    // Track ownership: set on a granted read, cleared on a release write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= 1'b0;
        else if (grant)
            held <= 1'b1;
        else if (wr_hit && wr_bit)
            held <= 1'b0;
    end

    assert_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> held);
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_bit) |=> !held);
    assert_noop_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !wr_bit) |=> $stable(held));
endmodule

// File: rtl/steer_copy_array.sv
// Per-unit register copies with broadcast or steered write and steered read.
// Assumes unit_en is stable around the write edge it qualifies.
module steer_copy_array #(
    parameter int N  = 16,
    parameter int DW = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_mcast,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wdata,
    input  logic [N-1:0]  unit_en,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic          rd_enabled
);
    logic [DW-1:0] copies [N];

    for (genvar u = 0; u < N; u++) begin : g_unit
        logic hit;
        assign hit = wr_en && unit_en[u] && (wr_mcast || wr_idx == IW'(u));

        // Each copy takes the write only when its unit is enabled and targeted.
        always_ff @(posedge clk) begin
            if (!rst_n)
                copies[u] <= '0;
            else if (hit)
                copies[u] <= wdata;
        end

        assert_disabled_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !unit_en[u]) |=> $stable(copies[u]));
        assert_other_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_mcast && wr_idx != IW'(u)) |=> $stable(copies[u]));
        assert_bcast_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_mcast && unit_en[u]) |=> copies[u] == $past(wdata));
    end

    // Steered read selects one copy and reports whether its unit is enabled.
    assign rd_data    = copies[rd_idx];
    assign rd_enabled = unit_en[rd_idx];
endmodule

// File: rtl/steer_reg_bank.sv
// Top: decodes the address, steers into the copy array, registers the reply.
// Assumes one request per cycle and a single-cycle read latency.
module steer_reg_bank
    import steer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [NUM_UNITS-1:0] unit_enable,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata
);
    logic              rd_req, wr_req;
    logic              sel_mcast;
    logic [GRP_W-1:0]  sel_grp;
    logic [INST_W-1:0] sel_inst;
    logic [DATA_W-1:0] sel_word;
    logic [UNIT_W-1:0] unit_idx;
    logic [DATA_W-1:0] copy_data;
    logic              copy_en;
    logic              sem_grant, sem_held;
    logic [DATA_W-1:0] rd_mux;

    assign rd_req = req_valid && !req_write;
    assign wr_req = req_valid && req_write;
    assign unit_idx = UNIT_W'(sel_grp) * UNIT_W'(NUM_INST) + UNIT_W'(sel_inst);

    steer_selector u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_req && req_addr == ADDR_SEL),
        .wr_mcast (req_wdata[0]),
        .wr_grp   (req_wdata[GRP_LSB +: GRP_W]),
        .wr_inst  (req_wdata[INST_LSB +: INST_W]),
        .mcast    (sel_mcast),
        .grp      (sel_grp),
        .inst     (sel_inst),
        .sel_word (sel_word)
    );

    steer_semaphore u_sem (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_hit (rd_req && req_addr == ADDR_SEM),
        .wr_hit (wr_req && req_addr == ADDR_SEM),
        .wr_bit (req_wdata[0]),
        .grant  (sem_grant),
        .held   (sem_held)
    );

    steer_copy_array #(.N(NUM_UNITS), .DW(DATA_W)) u_copies (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_req && req_addr == ADDR_DATA),
        .wr_mcast   (sel_mcast),
        .wr_idx     (unit_idx),
        .wdata      (req_wdata),
        .unit_en    (unit_enable),
        .rd_idx     (unit_idx),
        .rd_data    (copy_data),
        .rd_enabled (copy_en)
    );

    // Choose the read source by address; disabled units read as zero.
    always_comb begin
        case (req_addr)
            ADDR_DATA: rd_mux = copy_en ? copy_data : '0;
            ADDR_SEL:  rd_mux = sel_word;
            ADDR_SEM:  rd_mux = {{(DATA_W-1){1'b0}}, sem_grant};
            default:   rd_mux = '0;
        endcase
    end

    // Register the reply so it appears one cycle after the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_req;
            rsp_rdata <= rd_req ? rd_mux : '0;
        end
    end

    assert_rsp_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);
    assert_no_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid);
    assert_gated_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_addr == ADDR_DATA && !copy_en) |=> rsp_rdata == '0);
    assert_held_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_addr == ADDR_SEM && sem_held) |=> rsp_rdata == '0);
endmodule

// File: tb/sim_steer_reg_bank.sv
module sim_steer_reg_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NU = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_addr = 2'd0;
    logic [31:0] req_wdata = '0;
    logic [15:0] unit_enable = '1;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [31:0] model [NU];

    steer_reg_bank u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .unit_enable(unit_enable),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected=done", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R10 no response to write", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 response valid", {31'b0, rsp_valid}, 32'd1);
        d = rsp_rdata;
    endtask

    function automatic logic [31:0] sel_val(bit mc, int u);
        return {14'b0, 2'(u % 4), 6'b0, 2'(u / 4), 7'b0, mc};
    endfunction

    initial begin
        logic [31:0] d;
        for (int u = 0; u < NU; u++) model[u] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(2'd1, d); check("R1 selector reset", d, 32'h1);
        rd(2'd0, d); check("R1 copy zero", d, 32'h0);

        // R2/R6: broadcast to all enabled, read each with both flag values
        wr(2'd0, 32'hA5A5_0001);
        for (int u = 0; u < NU; u++) model[u] = 32'hA5A5_0001;
        for (int u = 0; u < NU; u++) begin
            wr(2'd1, sel_val(1'b1, u)); rd(2'd0, d); check("R2 broadcast", d, model[u]);
            wr(2'd1, sel_val(1'b0, u)); rd(2'd0, d); check("R6 flag clear", d, model[u]);
        end

        // R3/R7: broadcast under sparse mask
        wr(2'd1, 32'h1);
        unit_enable = 16'h5A5A;
        wr(2'd0, 32'h0BAD_0002);
        for (int u = 0; u < NU; u++) if (unit_enable[u]) model[u] = 32'h0BAD_0002;
        for (int u = 0; u < NU; u++) begin
            wr(2'd1, sel_val(1'b1, u)); rd(2'd0, d);
            check("R7 gated read", d, unit_enable[u] ? model[u] : 32'h0);
        end
        unit_enable = '1;
        for (int u = 0; u < NU; u++) begin
            wr(2'd1, sel_val(1'b1, u)); rd(2'd0, d); check("R3 disabled kept", d, model[u]);
        end

        // R4/R5: steered writes with some units disabled
        unit_enable = 16'hF0F0;
        for (int u = 0; u < NU; u++) begin
            wr(2'd1, sel_val(1'b0, u));
            wr(2'd0, 32'h1000_0000 + 32'(u * 17));
            if (unit_enable[u]) model[u] = 32'h1000_0000 + 32'(u * 17);
        end
        unit_enable = '1;
        for (int u = 0; u < NU; u++) begin
            wr(2'd1, sel_val(1'b0, u)); rd(2'd0, d);
            if (u < 4 || (u >= 8 && u < 12)) check("R5 dropped write", d, model[u]);
            else check("R4 steered write", d, model[u]);
        end

        // R8/R9: semaphore
        rd(2'd2, d); check("R8 free grants", d, 32'h1);
        rd(2'd2, d); check("R8 held denies", d, 32'h0);
        wr(2'd2, 32'h2);
        rd(2'd2, d); check("R9 bit0 clear no release", d, 32'h0);
        wr(2'd2, 32'h1);
        rd(2'd2, d); check("R9 release", d, 32'h1);
        wr(2'd2, 32'h1);

        // R11: selector field layout and unused address
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); check("R11 selector layout", d, 32'h0003_0301);
        rd(2'd3, d); check("R11 unused address", d, 32'h0);
        wr(2'd1, 32'h1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule